// File: doc/BRIEF.md
# Trap-Return State Update Unit

This unit carries out the two trap-return operations of a processor core: return from a supervisor-level trap and return from a machine-level trap. The pipeline raises `req_valid` for one cycle. With it come the kind of return and a snapshot of the architectural state that the return depends on:

- the current privilege level and virtualization state;
- the machine status word and the hypervisor status word;
- both saved exception PCs;
- the feature flags and the number of configured protection rules.

The unit first decides whether the return may proceed. When several faults apply, it reports only the one with the highest priority. If the return is allowed, the unit computes the rewritten status words, the privilege and virtualization state to resume in, and the PC to jump to. If the return is not allowed, it reports a trap code and echoes the incoming state unchanged.

All results are registered. They appear together with `done_valid` in the cycle after the request. Swapping the guest and host register banks is handled elsewhere; this unit only raises a one-cycle `swap_req` when that swap is needed.

Privilege encoding is U = 0, S = 1, M = 3. The status words use these bit positions:

| Word | Bit(s) | Field |
|---|---|---|
| status | 1 | SIE |
| status | 3 | MIE |
| status | 5 | SPIE |
| status | 7 | MPIE |
| status | 8 | SPP |
| status | 12:11 | MPP |
| status | 17 | MPRV |
| status | 22 | trap-supervisor-return |
| status | 39 | MPV |
| hstatus | 7 | SPV |
| hstatus | 22 | virtual trap-supervisor-return |

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return requested at privilege U (0) reports trap code 2 (illegal instruction).
- R2: A machine return requested at any privilege other than M (3) reports trap code 2.
- R3: When `has_c` is 0 and bits [1:0] of the selected exception PC (`sepc_in` for supervisor return, `mepc_in` for machine return) are nonzero, the unit reports trap code 0 (misaligned target). When `has_c` is 1, those bits cause no trap.
- R4: A supervisor return with status bit 22 set reports trap code 2 when the privilege is below M. At M the same return proceeds.
- R5: A supervisor return with `cur_virt` = 1 and hstatus bit 22 set reports trap code 22 (virtual instruction).
- R6: A successful supervisor return makes the following changes:
  - `next_priv` becomes {0, status bit 8};
  - bit 1 takes the old value of bit 5;
  - bit 5 becomes 1;
  - bit 8 becomes 0.
- R7: A successful machine return makes the following changes:
  - `next_priv` becomes the old bits 12:11;
  - bit 3 takes the old value of bit 7;
  - bit 7 becomes 1;
  - bits 12:11 become 0 if `has_u` is 1, and 3 otherwise;
  - bit 39 becomes 0.
- R8: With `ver_1p12` = 1, status bit 17 is cleared by every successful supervisor return. It is cleared by a successful machine return only when the old bits 12:11 are not 3. With `ver_1p12` = 0, bit 17 is never changed.
- R9: A machine return with `has_pmp` = 1, `pmp_rules` = 0 and old bits 12:11 not equal to 3 reports trap code 1 (fetch access fault).
- R10: A successful supervisor return with `has_h` = 1 and `cur_virt` = 0 sets `next_virt` to hstatus bit 7 and clears that bit. It pulses `swap_req` when the new state is virtualized. In all other cases `next_virt` equals `cur_virt` and hstatus is unchanged.
- R11: A successful machine return with `has_h` = 1 sets `next_virt` to the old status bit 39 and pulses `swap_req` when that bit is 1. Without `has_h`, `next_virt` equals `cur_virt`.
- R12: Every output is valid, with `done_valid` high, exactly one cycle after `req_valid`.
  - On a trap: `exc_valid` is 1, the status words, privilege and virtualization state are echoed unchanged, `ret_pc` is 0 and `swap_req` stays 0.
  - On success: `ret_pc` is the selected exception PC.
  - After reset: `done_valid`, `exc_valid` and `swap_req` are 0, and `next_priv` is 3.
- R13: Trap conditions are ranked in this order:
  - privilege too low;
  - misaligned target;
  - for a supervisor return, the bit-22 trap; for a machine return, the protection fault;
  - the virtual trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle trap-return request |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization state |
| status_in | input | STAT_W | Current machine status word |
| hstatus_in | input | STAT_W | Current hypervisor status word |
| sepc_in | input | XLEN | Supervisor exception PC |
| mepc_in | input | XLEN | Machine exception PC |
| has_c | input | 1 | Compressed instructions supported |
| has_u | input | 1 | User mode present |
| has_h | input | 1 | Hypervisor extension present |
| has_pmp | input | 1 | Physical memory protection present |
| pmp_rules | input | PMP_CNT_W | Number of configured protection rules |
| ver_1p12 | input | 1 | Privileged-spec version 1.12 or later |
| done_valid | output | 1 | Results below are valid |
| exc_valid | output | 1 | The return trapped |
| exc_code | output | 5 | Trap code (0, 1, 2 or 22) |
| status_out | output | STAT_W | Updated status word |
| hstatus_out | output | STAT_W | Updated hypervisor status word |
| next_priv | output | 2 | Privilege to resume in |
| next_virt | output | 1 | Virtualization state to resume in |
| ret_pc | output | XLEN | Return target PC |
| swap_req | output | 1 | One-cycle request to swap register banks |

## Verification
Every result of this unit is due in a single cycle: the cycle after the request, counted through the one output register stage. The bench drives each request on a falling edge and computes the expected record from the same inputs with its own behavioural model. On the next falling edge, after the rising edge that loads the outputs, it compares every output. It also confirms on every idle cycle that `done_valid` and `swap_req` are low, so a late or repeated response is caught.

// File: rtl/trap_return_pkg.sv
package trap_return_pkg;

  // privilege encodings
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // status word field positions
  localparam int B_SIE    = 1;
  localparam int B_MIE    = 3;
  localparam int B_SPIE   = 5;
  localparam int B_MPIE   = 7;
  localparam int B_SPP    = 8;
  localparam int B_MPP_LO = 11;
  localparam int B_MPP_HI = 12;
  localparam int B_MPRV   = 17;
  localparam int B_TSR    = 22;
  localparam int B_MPV    = 39;

  // hypervisor status word field positions
  localparam int B_SPV    = 7;
  localparam int B_VTSR   = 22;

  localparam int EXC_W = 5;
  typedef enum logic [EXC_W-1:0] {
    EXC_MISALIGN = 5'd0,
    EXC_FETCH_AF = 5'd1,
    EXC_ILLEGAL  = 5'd2,
    EXC_VIRT     = 5'd22
  } exc_code_t;

endpackage

// File: rtl/tr_legal_chk.sv
module tr_legal_chk
  import trap_return_pkg::*;
#(
  parameter int PMP_CNT_W = 7
) (
  input  logic                 is_mret,
  input  logic [1:0]           cur_priv,
  input  logic                 cur_virt,
  input  logic                 tsr_bit,
  input  logic                 vtsr_bit,
  input  logic [1:0]           mpp,
  input  logic [1:0]           epc_lo,
  input  logic                 has_c,
  input  logic                 has_pmp,
  input  logic [PMP_CNT_W-1:0] pmp_rules,
  output logic                 trap,
  output exc_code_t            code
);

  logic misalign;
  logic no_rules;

  assign misalign = !has_c && (epc_lo != 2'b00);
  assign no_rules = has_pmp && (pmp_rules == '0) && (mpp != PRIV_M);

  // ranked priority: privilege, alignment, trap bits / protection, virtual
  always_comb begin
    trap = 1'b0;
    code = EXC_ILLEGAL;
    if (is_mret) begin
      if (cur_priv != PRIV_M) begin
        trap = 1'b1;
        code = EXC_ILLEGAL;
      end else if (misalign) begin
        trap = 1'b1;
        code = EXC_MISALIGN;
      end else if (no_rules) begin
        trap = 1'b1;
        code = EXC_FETCH_AF;
      end
    end else begin
      if (cur_priv == PRIV_U) begin
        trap = 1'b1;
        code = EXC_ILLEGAL;
      end else if (misalign) begin
        trap = 1'b1;
        code = EXC_MISALIGN;
      end else if (tsr_bit && cur_priv != PRIV_M) begin
        trap = 1'b1;
        code = EXC_ILLEGAL;
      end else if (cur_virt && vtsr_bit) begin
        trap = 1'b1;
        code = EXC_VIRT;
      end
    end
  end

endmodule

// File: rtl/tr_state_calc.sv
module tr_state_calc
  import trap_return_pkg::*;
#(
  parameter int STAT_W = 64
) (
  input  logic              is_mret,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] hstatus,
  input  logic              cur_virt,
  input  logic              has_u,
  input  logic              has_h,
  input  logic              ver_1p12,
  output logic [STAT_W-1:0] new_status,
  output logic [STAT_W-1:0] new_hstatus,
  output logic [1:0]        new_priv,
  output logic              new_virt,
  output logic              swap
);

  logic [1:0] old_mpp;
  assign old_mpp = status[B_MPP_HI:B_MPP_LO];

  always_comb begin
    new_status  = status;
    new_hstatus = hstatus;
    new_priv    = PRIV_U;
    new_virt    = cur_virt;
    swap        = 1'b0;
    if (is_mret) begin
      new_priv                        = old_mpp;
      new_status[B_MIE]               = status[B_MPIE];
      new_status[B_MPIE]              = 1'b1;
      new_status[B_MPP_HI:B_MPP_LO]   = has_u ? PRIV_U : PRIV_M;
      new_status[B_MPV]               = 1'b0;
      if (ver_1p12 && old_mpp != PRIV_M) new_status[B_MPRV] = 1'b0;
      if (has_h) begin
        new_virt = status[B_MPV];
        swap     = status[B_MPV];
      end
    end else begin
      new_priv           = {1'b0, status[B_SPP]};
      new_status[B_SIE]  = status[B_SPIE];
      new_status[B_SPIE] = 1'b1;
      new_status[B_SPP]  = 1'b0;
      if (ver_1p12) new_status[B_MPRV] = 1'b0;
      if (has_h && !cur_virt) begin
        new_virt           = hstatus[B_SPV];
        new_hstatus[B_SPV] = 1'b0;
        swap               = hstatus[B_SPV];
      end
    end
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_return_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int STAT_W    = 64,
  parameter int PMP_CNT_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_is_mret,
  input  logic [1:0]           cur_priv,
  input  logic                 cur_virt,
  input  logic [STAT_W-1:0]    status_in,
  input  logic [STAT_W-1:0]    hstatus_in,
  input  logic [XLEN-1:0]      sepc_in,
  input  logic [XLEN-1:0]      mepc_in,
  input  logic                 has_c,
  input  logic                 has_u,
  input  logic                 has_h,
  input  logic                 has_pmp,
  input  logic [PMP_CNT_W-1:0] pmp_rules,
  input  logic                 ver_1p12,
  output logic                 done_valid,
  output logic                 exc_valid,
  output logic [4:0]           exc_code,
  output logic [STAT_W-1:0]    status_out,
  output logic [STAT_W-1:0]    hstatus_out,
  output logic [1:0]           next_priv,
  output logic                 next_virt,
  output logic [XLEN-1:0]      ret_pc,
  output logic                 swap_req
);

  logic [XLEN-1:0]   epc_sel;
  logic              trap;
  exc_code_t         code;
  logic [STAT_W-1:0] calc_status;
  logic [STAT_W-1:0] calc_hstatus;
  logic [1:0]        calc_priv;
  logic              calc_virt;
  logic              calc_swap;

  assign epc_sel = req_is_mret ? mepc_in : sepc_in;

  tr_legal_chk #(.PMP_CNT_W(PMP_CNT_W)) legal_i (
    .is_mret   (req_is_mret),
    .cur_priv  (cur_priv),
    .cur_virt  (cur_virt),
    .tsr_bit   (status_in[B_TSR]),
    .vtsr_bit  (hstatus_in[B_VTSR]),
    .mpp       (status_in[B_MPP_HI:B_MPP_LO]),
    .epc_lo    (epc_sel[1:0]),
    .has_c     (has_c),
    .has_pmp   (has_pmp),
    .pmp_rules (pmp_rules),
    .trap      (trap),
    .code      (code)
  );

  tr_state_calc #(.STAT_W(STAT_W)) calc_i (
    .is_mret     (req_is_mret),
    .status      (status_in),
    .hstatus     (hstatus_in),
    .cur_virt    (cur_virt),
    .has_u       (has_u),
    .has_h       (has_h),
    .ver_1p12    (ver_1p12),
    .new_status  (calc_status),
    .new_hstatus (calc_hstatus),
    .new_priv    (calc_priv),
    .new_virt    (calc_virt),
    .swap        (calc_swap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid  <= 1'b0;
      exc_valid   <= 1'b0;
      exc_code    <= '0;
      status_out  <= '0;
      hstatus_out <= '0;
      next_priv   <= PRIV_M;
      next_virt   <= 1'b0;
      ret_pc      <= '0;
      swap_req    <= 1'b0;
    end else if (req_valid) begin
      done_valid <= 1'b1;
      exc_valid  <= trap;
      exc_code   <= trap ? code : '0;
      if (trap) begin
        status_out  <= status_in;
        hstatus_out <= hstatus_in;
        next_priv   <= cur_priv;
        next_virt   <= cur_virt;
        ret_pc      <= '0;
        swap_req    <= 1'b0;
      end else begin
        status_out  <= calc_status;
        hstatus_out <= calc_hstatus;
        next_priv   <= calc_priv;
        next_virt   <= calc_virt;
        ret_pc      <= epc_sel;
        swap_req    <= calc_swap;
      end
    end else begin
      done_valid <= 1'b0;
      swap_req   <= 1'b0;
    end
  end

endmodule

// File: rtl/trap_return_unit_chk.sv
module trap_return_unit_chk
  import trap_return_pkg::*;
#(
  parameter int STAT_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_is_mret,
  input logic [1:0]        cur_priv,
  input logic              has_c,
  input logic [1:0]        mepc_lo,
  input logic [STAT_W-1:0] status_in,
  input logic [STAT_W-1:0] status_out,
  input logic [1:0]        next_priv,
  input logic              next_virt,
  input logic              exc_valid,
  input logic [4:0]        exc_code,
  input logic              done_valid,
  input logic              swap_req
);

  // R1
  sret_low_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_mret && cur_priv == PRIV_U) |=> (exc_valid && exc_code == 5'd2));

  // R2
  mret_low_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_mret && cur_priv != PRIV_M) |=> (exc_valid && exc_code == 5'd2));

  // R3
  mret_misalign_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_mret && cur_priv == PRIV_M && !has_c && mepc_lo != 2'b00)
      |=> (exc_valid && exc_code == 5'd0));

  // R12
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_valid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!done_valid && !swap_req));

  // R12
  trap_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && exc_valid) |-> (status_out == $past(status_in) &&
                                   next_priv == $past(cur_priv) && !swap_req));

  // R7
  mret_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !exc_valid && $past(req_is_mret))
      |-> (status_out[B_MPIE] && !status_out[B_MPV]));

  // R6
  sret_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !exc_valid && !$past(req_is_mret))
      |-> (status_out[B_SPIE] && !status_out[B_SPP]));

  // R10
  swap_needs_virt_chk: assert property (@(posedge clk) disable iff (rst)
    swap_req |-> (next_virt && done_valid));

endmodule

bind trap_return_unit trap_return_unit_chk #(.STAT_W(STAT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_is_mret (req_is_mret),
  .cur_priv    (cur_priv),
  .has_c       (has_c),
  .mepc_lo     (mepc_in[1:0]),
  .status_in   (status_in),
  .status_out  (status_out),
  .next_priv   (next_priv),
  .next_virt   (next_virt),
  .exc_valid   (exc_valid),
  .exc_code    (exc_code),
  .done_valid  (done_valid),
  .swap_req    (swap_req)
);

// File: tb/trap_return_unit_tb_top.sv
`timescale 1ns/1ps
module trap_return_unit_tb_top;

  localparam int XLEN = 32;
  localparam int SW   = 64;
  localparam int PW   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            req_valid = 0, is_mret = 0, cur_virt = 0;
  logic [1:0]      cur_priv = 2'd3;
  logic [SW-1:0]   st = '0, hst = '0;
  logic [XLEN-1:0] sepc = '0, mepc = '0;
  logic            has_c = 1, has_u = 1, has_h = 0, has_pmp = 0, ver = 0;
  logic [PW-1:0]   pmp_rules = '0;

  logic            done_valid, exc_valid, next_virt, swap_req;
  logic [4:0]      exc_code;
  logic [SW-1:0]   status_out, hstatus_out;
  logic [1:0]      next_priv;
  logic [XLEN-1:0] ret_pc;

  trap_return_unit #(.XLEN(XLEN), .STAT_W(SW), .PMP_CNT_W(PW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_mret(is_mret),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .status_in(st), .hstatus_in(hst),
    .sepc_in(sepc), .mepc_in(mepc), .has_c(has_c), .has_u(has_u), .has_h(has_h),
    .has_pmp(has_pmp), .pmp_rules(pmp_rules), .ver_1p12(ver),
    .done_valid(done_valid), .exc_valid(exc_valid), .exc_code(exc_code),
    .status_out(status_out), .hstatus_out(hstatus_out), .next_priv(next_priv),
    .next_virt(next_virt), .ret_pc(ret_pc), .swap_req(swap_req)
  );

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  // expected record
  logic            e_exc, e_virt, e_swap;
  int              e_code;
  logic [SW-1:0]   e_st, e_hst;
  logic [1:0]      e_priv;
  logic [XLEN-1:0] e_pc;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference from the requirement list
  function automatic void model();
    logic [XLEN-1:0] pc;
    bit misal;
    int mpp;
    pc    = is_mret ? mepc : sepc;
    misal = !has_c && (pc % 4 != 0);
    mpp   = int'(st[12:11]);
    e_exc = 1; e_code = 0;
    if (is_mret) begin
      if (cur_priv != 3)                           e_code = 2;
      else if (misal)                              e_code = 0;
      else if (has_pmp && pmp_rules == 0 && mpp != 3) e_code = 1;
      else e_exc = 0;
    end else begin
      if (cur_priv == 0)                           e_code = 2;
      else if (misal)                              e_code = 0;
      else if (st[22] && cur_priv != 3)            e_code = 2;
      else if (cur_virt && hst[22])                e_code = 22;
      else e_exc = 0;
    end
    e_st = st; e_hst = hst; e_priv = cur_priv; e_virt = cur_virt;
    e_swap = 0; e_pc = 0;
    if (!e_exc) begin
      e_pc = pc;
      if (is_mret) begin
        e_priv    = st[12:11];
        e_st[3]   = st[7];
        e_st[7]   = 1;
        e_st[12:11] = has_u ? 2'd0 : 2'd3;
        e_st[39]  = 0;
        if (ver && mpp != 3) e_st[17] = 0;
        if (has_h) begin e_virt = st[39]; e_swap = st[39]; end
      end else begin
        e_priv   = {1'b0, st[8]};
        e_st[1]  = st[5];
        e_st[5]  = 1;
        e_st[8]  = 0;
        if (ver) e_st[17] = 0;
        if (has_h && !cur_virt) begin
          e_virt = hst[7]; e_swap = hst[7]; e_hst[7] = 0;
        end
      end
    end
  endfunction

  // one request: drive at falling edge, compare at the next falling edge
  task automatic do_req(string tag);
    model();
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check({tag, " R12 done"}, done_valid, 1);
    check({tag, " exc"}, exc_valid, e_exc);
    if (e_exc) check({tag, " code"}, exc_code, e_code);
    check({tag, " status"}, status_out, e_st);
    check({tag, " hstatus"}, hstatus_out, e_hst);
    check({tag, " priv"}, next_priv, e_priv);
    check({tag, " virt"}, next_virt, e_virt);
    check({tag, " pc"}, ret_pc, e_pc);
    check({tag, " swap"}, swap_req, e_swap);
    @(negedge clk);
    check("R12 idle done", done_valid, 0);
    check("R12 idle swap", swap_req, 0);
  endtask

  task automatic defaults();
    is_mret = 0; cur_priv = 2'd3; cur_virt = 0; st = '0; hst = '0;
    sepc = 32'h1000; mepc = 32'h2000; has_c = 1; has_u = 1; has_h = 0;
    has_pmp = 0; pmp_rules = '0; ver = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R12 reset done", done_valid, 0);
    check("R12 reset exc", exc_valid, 0);
    check("R12 reset swap", swap_req, 0);
    check("R12 reset priv", next_priv, 3);

    defaults(); cur_priv = 0; do_req("R1 sret at U");
    defaults(); cur_priv = 1; is_mret = 1; do_req("R2 mret at S");
    defaults(); cur_priv = 0; is_mret = 1; do_req("R2 mret at U");
    defaults(); has_c = 0; sepc = 32'h1002; cur_priv = 1; do_req("R3 sret misaligned");
    defaults(); has_c = 0; mepc = 32'h2001; is_mret = 1; do_req("R3 mret misaligned");
    defaults(); has_c = 1; mepc = 32'h2002; is_mret = 1; do_req("R3 compressed ok");
    defaults(); cur_priv = 1; st[22] = 1; do_req("R4 tsr at S");
    defaults(); cur_priv = 3; st[22] = 1; do_req("R4 tsr at M ok");
    defaults(); cur_priv = 1; cur_virt = 1; hst[22] = 1; do_req("R5 vtsr");
    defaults(); cur_priv = 1; st[5] = 1; st[8] = 1; st[17] = 1; do_req("R6 sret fields");
    defaults(); cur_priv = 1; st[8] = 0; st[1] = 1; ver = 1; st[17] = 1; do_req("R8 sret mprv");
    defaults(); is_mret = 1; st[7] = 1; st[12:11] = 1; st[39] = 1; do_req("R7 mret u");
    defaults(); is_mret = 1; has_u = 0; st[12:11] = 3; do_req("R7 mret no u");
    defaults(); is_mret = 1; ver = 1; st[17] = 1; st[12:11] = 3; do_req("R8 mret keeps mprv");
    defaults(); is_mret = 1; ver = 1; st[17] = 1; st[12:11] = 0; do_req("R8 mret clears mprv");
    defaults(); is_mret = 1; has_pmp = 1; st[12:11] = 1; do_req("R9 no rules");
    defaults(); is_mret = 1; has_pmp = 1; pmp_rules = 3; st[12:11] = 1; do_req("R9 rules ok");
    defaults(); cur_priv = 1; has_h = 1; hst[7] = 1; do_req("R10 spv restore");
    defaults(); cur_priv = 1; has_h = 1; cur_virt = 1; hst[7] = 1; do_req("R10 virt no restore");
    defaults(); is_mret = 1; has_h = 1; st[39] = 1; st[12:11] = 1; do_req("R11 mpv restore");
    defaults(); is_mret = 1; has_h = 0; st[39] = 1; do_req("R11 no hyp");
    defaults(); cur_priv = 0; has_c = 0; sepc = 32'h3; do_req("R13 priv first");
    defaults(); cur_priv = 1; has_c = 0; sepc = 32'h2; st[22] = 1; do_req("R13 misalign before tsr");
    defaults(); cur_priv = 1; cur_virt = 1; st[22] = 1; hst[22] = 1; do_req("R13 tsr before virt");
    defaults(); is_mret = 1; has_c = 0; mepc = 32'h1; has_pmp = 1; st[12:11] = 0; do_req("R13 misalign before pmp");

    for (int i = 0; i < 400; i++) begin
      is_mret   = $urandom_range(0, 1);
      cur_priv  = 2'($urandom_range(0, 3));
      cur_virt  = $urandom_range(0, 1);
      st        = {$urandom, $urandom};
      hst       = {$urandom, $urandom};
      sepc      = $urandom; mepc = $urandom;
      has_c     = $urandom_range(0, 1); has_u = $urandom_range(0, 1);
      has_h     = $urandom_range(0, 1); has_pmp = $urandom_range(0, 1);
      pmp_rules = 7'($urandom_range(0, 2));
      ver       = $urandom_range(0, 1);
      do_req("R13 random mix");
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule